// File: doc/BRIEF.md
# Audio transmit sample FIFO packer

This block sits between a register bus and the transmit side of an audio codec link. Software writes audio samples one word at a time. Each sample is converted on entry to a 20-bit slot format and stored in a circular buffer. When transmission is enabled and enough data has built up, the block hands the stored samples to a codec-side sink as left/right pairs, over a valid/ready handshake.

Two write modes are supported. In the single-sample mode, one write carries one sample of 12, 16, 18 or 20 bits, and the sample is left-aligned into the 20-bit slot. In the packed mode, one 32-bit write carries two 16-bit or 12-bit samples. The block also keeps four status flags: empty, half-empty, full and underrun. Interrupt generation is done by a separate block that reads these flags.

The buffer depth is a parameter. Legal values are 8, 32, 64, 128, 256, 512, 1024 and 2048. The block starts sending only after the buffer is at least half full. Once it has started, it keeps sending pairs until the sink refuses one or fewer than two entries remain.

Top module: `audio_tx_packer`

## Requirements
- R1: `ctl_size` selects the sample width: code 0 is 16 bits, code 1 is 18 bits, code 2 is 20 bits and code 3 is 12 bits. In single-sample mode the stored 20-bit slot is `smp_data` shifted left by 4 (16-bit), 2 (18-bit), 0 (20-bit) or 8 (12-bit), keeping the low 20 bits.
- R2: In packed mode, one write stores two entries. Bits [15:0] are stored first and bits [31:16] second. Each half is shifted left by 8 when code 3 is selected and by 4 otherwise, keeping the low 20 bits.
- R3: A control write that requests packed mode together with code 1 or code 2 leaves the block in single-sample mode.
- R4: A single-sample write is stored only when level < DEPTH. A packed write is stored only when level + 2 < DEPTH. Any other write is dropped and changes nothing.
- R5: On a stored write, with L the level after the write: L > 0 clears `st_empty` and `st_underrun`; L >= DEPTH/2 clears `st_half_empty`; L >= DEPTH sets `st_full`.
- R6: `snk_valid` is high only when all of these hold: transmit is enabled, at least one bit of `ctl_slot_sel` is set in the control register, the level is at least 2, and either the level is at least DEPTH/2 or a pair was accepted in the previous cycle.
- R7: `snk_pair` carries the oldest entry in bits [39:20] and the next entry in bits [19:0]. Each transfer with `snk_valid` and `snk_ready` both high removes those two entries. A refusal ends the current run of transfers.
- R8: After an accepted pair, with L the new level: `st_full` is cleared; `st_half_empty` is set if L <= DEPTH/2; `st_empty` and `st_underrun` are both set if L = 0.
- R9: Reset, or a cycle with `intf_wr` high and `intf_enable` low, does all of the following: empties the buffer; sets `st_empty` and `st_half_empty`; clears `st_full` and `st_underrun`; returns the control register to transmit off, no slots selected, code 0 and single-sample mode. In that cycle `snk_valid` is low and every other write is ignored.
- R10: A write in the same cycle as a control update uses the previous settings, and a store and a pair transfer can happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the transmit control register |
| ctl_tx_en | input | 1 | Transmit enable value |
| ctl_slot_sel | input | 2 | Audio slot selection; any set bit allows draining |
| ctl_size | input | 2 | Sample width code (see R1) |
| ctl_compact | input | 1 | Packed mode request |
| intf_wr | input | 1 | Write strobe for the interface enable |
| intf_enable | input | 1 | Interface enable value; writing 0 clears the block |
| smp_wr | input | 1 | Sample data write strobe |
| smp_data | input | 32 | Sample data word |
| snk_valid | output | 1 | A left/right pair is offered |
| snk_ready | input | 1 | Sink accepts the offered pair |
| snk_pair | output | 40 | Left slot [39:20], right slot [19:0] |
| st_empty | output | 1 | Empty flag |
| st_half_empty | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |

## Verification
The bench drives every width code in both modes with patterns whose bits above the sample width are set. A wrong shift or a missing 20-bit mask would show up as corrupted slot contents, and a swapped packing order as left and right halves trading places.

The bench fills the buffer past its limits in both modes. A design with an off-by-one in either room check would store one entry too many, which shifts every later pair or changes the level at which the full flag sets.

Backpressure arrives in the middle of a run while writes continue. A design that kept its run going after a refusal, or that started a run below half level, would offer pairs in cycles where the reference holds back.

The bench also checks the asymmetric half-empty thresholds (cleared at exactly half on a write, set at exactly half on a drain) and a clear in the middle of a fill. A design that skipped resetting the control register on a clear would start draining when it should stay idle.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

    localparam int SLOT_W = 20;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [1:0] {
        SZ16 = 2'd0,
        SZ18 = 2'd1,
        SZ20 = 2'd2,
        SZ12 = 2'd3
    } size_code_e;

    typedef struct packed {
        logic       tx_en;
        logic [1:0] slot_sel;
        size_code_e size;
        logic       compact;
    } tx_cfg_t;

    typedef struct packed {
        logic empty;
        logic half_empty;
        logic full;
        logic underrun;
    } tx_flags_t;

    // One sample per word: left-align into the 20-bit slot.
    function automatic slot_t align_single(size_code_e sz, logic [31:0] d);
        logic [31:0] t;
        case (sz)
            SZ12:    t = d << 8;
            SZ16:    t = d << 4;
            SZ18:    t = d << 2;
            default: t = d;
        endcase
        return t[SLOT_W-1:0];
    endfunction

    // One half of a packed word into the 20-bit slot.
    function automatic slot_t align_half(size_code_e sz, logic [15:0] h);
        slot_t t;
        if (sz == SZ12) t = {h[11:0], 8'h00};
        else            t = {h, 4'h0};
        return t;
    endfunction

    // Packed mode is only meaningful for the two narrow widths.
    function automatic logic packed_allowed(size_code_e sz);
        return (sz == SZ16) || (sz == SZ12);
    endfunction

endpackage

// File: rtl/audio_tx_cfg.sv
module audio_tx_cfg
    import audio_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       ctl_wr,
    input  logic       ctl_tx_en,
    input  logic [1:0] ctl_slot_sel,
    input  logic [1:0] ctl_size,
    input  logic       ctl_compact,
    output tx_cfg_t    cfg
);

    size_code_e size_in;
    assign size_in = size_code_e'(ctl_size);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cfg <= '0;
        end else if (ctl_wr) begin
            cfg.tx_en    <= ctl_tx_en;
            cfg.slot_sel <= ctl_slot_sel;
            cfg.size     <= size_in;
            cfg.compact  <= ctl_compact && packed_allowed(size_in);
        end
    end

    assert_packed_legal_R3: assert property (@(posedge clk) disable iff (rst)
        cfg.compact |-> (cfg.size == SZ16 || cfg.size == SZ12));

endmodule

// File: rtl/audio_tx_ring.sv
module audio_tx_ring
    import audio_tx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     push_one,
    input  logic                     push_two,
    input  slot_t                    wd_first,
    input  slot_t                    wd_second,
    input  logic                     pop,
    output slot_t                    rd_first,
    output slot_t                    rd_second,
    output logic [$clog2(DEPTH):0]   level
);

    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    slot_t           mem [DEPTH];
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   rptr;
    logic [AW-1:0]   wptr_nx;
    logic [AW-1:0]   rptr_nx;
    logic [LW-1:0]   add_n;
    logic [LW-1:0]   sub_n;

    assign wptr_nx = wptr + AW'(1);
    assign rptr_nx = rptr + AW'(1);
    assign add_n   = push_two ? LW'(2) : (push_one ? LW'(1) : LW'(0));
    assign sub_n   = pop ? LW'(2) : LW'(0);

    always_ff @(posedge clk) begin
        if (push_one || push_two) mem[wptr]    <= wd_first;
        if (push_two)             mem[wptr_nx] <= wd_second;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            wptr  <= wptr + add_n[AW-1:0];
            rptr  <= rptr + sub_n[AW-1:0];
            level <= level + add_n - sub_n;
        end
    end

    assign rd_first  = mem[rptr];
    assign rd_second = mem[rptr_nx];

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    assert_pop_has_pair_R7: assert property (@(posedge clk) disable iff (rst)
        pop |-> level >= LW'(2));

    assert_one_push_kind_R2: assert property (@(posedge clk) disable iff (rst)
        !(push_one && push_two));

endmodule

// File: rtl/audio_tx_flags.sv
module audio_tx_flags
    import audio_tx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   pushed,
    input  logic                   popped,
    input  logic [$clog2(DEPTH):0] lvl_mid,
    input  logic [$clog2(DEPTH):0] lvl_new,
    output tx_flags_t              flags
);

    localparam int LW = $clog2(DEPTH) + 1;
    localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);
    localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

    tx_flags_t nx;

    always_comb begin
        nx = flags;
        if (pushed) begin
            if (lvl_mid != '0) begin
                nx.empty    = 1'b0;
                nx.underrun = 1'b0;
            end
            if (lvl_mid >= HALF_L) nx.half_empty = 1'b0;
            if (lvl_mid >= FULL_L) nx.full = 1'b1;
        end
        if (popped) begin
            nx.full = 1'b0;
            if (lvl_new <= HALF_L) nx.half_empty = 1'b1;
            if (lvl_new == '0) begin
                nx.empty    = 1'b1;
                nx.underrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flags <= '{empty: 1'b1, half_empty: 1'b1, full: 1'b0, underrun: 1'b0};
        end else begin
            flags <= nx;
        end
    end

    assert_clear_state_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (flags.empty && flags.half_empty && !flags.full && !flags.underrun));

    assert_full_not_empty_R5: assert property (@(posedge clk) disable iff (rst)
        flags.full |-> !flags.empty);

    assert_underrun_with_empty_R8: assert property (@(posedge clk) disable iff (rst)
        flags.underrun |-> flags.empty);

endmodule

// File: rtl/audio_tx_packer.sv
module audio_tx_packer
    import audio_tx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic        ctl_tx_en,
    input  logic [1:0]  ctl_slot_sel,
    input  logic [1:0]  ctl_size,
    input  logic        ctl_compact,
    input  logic        intf_wr,
    input  logic        intf_enable,
    input  logic        smp_wr,
    input  logic [31:0] smp_data,
    output logic        snk_valid,
    input  logic        snk_ready,
    output logic [39:0] snk_pair,
    output logic        st_empty,
    output logic        st_half_empty,
    output logic        st_full,
    output logic        st_underrun
);

    localparam int AW   = $clog2(DEPTH);
    localparam int LW   = AW + 1;
    localparam int HALF = DEPTH / 2;

    initial begin
        assert (DEPTH == 8 || DEPTH == 32 || DEPTH == 64 || DEPTH == 128 ||
                DEPTH == 256 || DEPTH == 512 || DEPTH == 1024 || DEPTH == 2048)
            else $error("audio_tx_packer: unsupported DEPTH %0d", DEPTH);
    end

    tx_cfg_t       cfg;
    tx_flags_t     flags;
    logic          clr;
    logic [LW-1:0] level;
    logic [LW:0]   level_p2;
    logic          room_one;
    logic          room_two;
    logic          push_one;
    logic          push_two;
    slot_t         wd_first;
    slot_t         wd_second;
    slot_t         rd_first;
    slot_t         rd_second;
    logic          drain_ok;
    logic          burst_q;
    logic          pop;
    logic [LW-1:0] lvl_mid;
    logic [LW-1:0] lvl_new;

    assign clr = intf_wr && !intf_enable;

    audio_tx_cfg u_cfg (
        .clk          (clk),
        .rst          (rst),
        .clr          (clr),
        .ctl_wr       (ctl_wr),
        .ctl_tx_en    (ctl_tx_en),
        .ctl_slot_sel (ctl_slot_sel),
        .ctl_size     (ctl_size),
        .ctl_compact  (ctl_compact),
        .cfg          (cfg)
    );

    // Room checks against the level before this cycle's activity.
    assign level_p2 = {1'b0, level} + (LW+1)'(2);
    assign room_one = level < LW'(DEPTH);
    assign room_two = level_p2 < (LW+1)'(DEPTH);

    assign push_one = smp_wr && !clr && !cfg.compact && room_one;
    assign push_two = smp_wr && !clr &&  cfg.compact && room_two;

    assign wd_first  = cfg.compact ? align_half(cfg.size, smp_data[15:0])
                                   : align_single(cfg.size, smp_data);
    assign wd_second = align_half(cfg.size, smp_data[31:16]);

    // Drain: a run opens at half level and continues on back-to-back accepts.
    assign drain_ok  = cfg.tx_en && (cfg.slot_sel != 2'b00);
    assign snk_valid = drain_ok && !clr && (level >= LW'(2)) &&
                       (burst_q || (level >= LW'(HALF)));
    assign pop       = snk_valid && snk_ready;

    always_ff @(posedge clk) begin
        if (rst || clr) burst_q <= 1'b0;
        else            burst_q <= pop;
    end

    audio_tx_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .push_one  (push_one),
        .push_two  (push_two),
        .wd_first  (wd_first),
        .wd_second (wd_second),
        .pop       (pop),
        .rd_first  (rd_first),
        .rd_second (rd_second),
        .level     (level)
    );

    assign snk_pair = {rd_first, rd_second};

    assign lvl_mid = level + (push_two ? LW'(2) : (push_one ? LW'(1) : LW'(0)));
    assign lvl_new = lvl_mid - (pop ? LW'(2) : LW'(0));

    audio_tx_flags #(.DEPTH(DEPTH)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .pushed  (push_one || push_two),
        .popped  (pop),
        .lvl_mid (lvl_mid),
        .lvl_new (lvl_new),
        .flags   (flags)
    );

    assign st_empty      = flags.empty;
    assign st_half_empty = flags.half_empty;
    assign st_full       = flags.full;
    assign st_underrun   = flags.underrun;

    assert_sink_gate_R6: assert property (@(posedge clk) disable iff (rst)
        snk_valid |-> (cfg.tx_en && cfg.slot_sel != 2'b00 && level >= LW'(2)));

    assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        (smp_wr && !clr && !pop && !cfg.compact && level == LW'(DEPTH))
            |=> (level == LW'(DEPTH)));

    assert_clear_no_offer_R9: assert property (@(posedge clk) disable iff (rst)
        clr |-> !snk_valid);

endmodule

// File: tb/audio_tx_packer_bench.sv
module audio_tx_packer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int HALF       = DEPTH / 2;
    localparam int WD_LIMIT   = 20000;

    logic        clk;
    logic        rst;
    logic        ctl_wr;
    logic        ctl_tx_en;
    logic [1:0]  ctl_slot_sel;
    logic [1:0]  ctl_size;
    logic        ctl_compact;
    logic        intf_wr;
    logic        intf_enable;
    logic        smp_wr;
    logic [31:0] smp_data;
    logic        snk_valid;
    logic        snk_ready;
    logic [39:0] snk_pair;
    logic        st_empty;
    logic        st_half_empty;
    logic        st_full;
    logic        st_underrun;

    audio_tx_packer #(.DEPTH(DEPTH)) u_audio_tx_packer (
        .clk           (clk),
        .rst           (rst),
        .ctl_wr        (ctl_wr),
        .ctl_tx_en     (ctl_tx_en),
        .ctl_slot_sel  (ctl_slot_sel),
        .ctl_size      (ctl_size),
        .ctl_compact   (ctl_compact),
        .intf_wr       (intf_wr),
        .intf_enable   (intf_enable),
        .smp_wr        (smp_wr),
        .smp_data      (smp_data),
        .snk_valid     (snk_valid),
        .snk_ready     (snk_ready),
        .snk_pair      (snk_pair),
        .st_empty      (st_empty),
        .st_half_empty (st_half_empty),
        .st_full       (st_full),
        .st_underrun   (st_underrun)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R9";

    // Reference model state
    bit [19:0] q[$];
    bit        m_e, m_h, m_f, m_u, m_burst;
    bit        m_en, m_comp;
    bit [1:0]  m_slot;
    int        m_size;

    function automatic bit [19:0] ref_single(int code, bit [31:0] d);
        bit [31:0] t;
        case (code)
            3:       t = d << 8;
            0:       t = d << 4;
            1:       t = d << 2;
            default: t = d;
        endcase
        return t[19:0];
    endfunction

    function automatic bit [19:0] ref_half(int code, bit [15:0] h);
        bit [31:0] t;
        t = {16'h0, h};
        t = (code == 3) ? (t << 8) : (t << 4);
        return t[19:0];
    endfunction

    function automatic bit model_valid();
        int n;
        n = q.size();
        return m_en && (m_slot != 2'b00) && !(intf_wr && !intf_enable) &&
               (n >= 2) && (m_burst || n >= HALF);
    endfunction

    task automatic model_clear();
        q.delete();
        m_e = 1; m_h = 1; m_f = 0; m_u = 0; m_burst = 0;
        m_en = 0; m_slot = 2'b00; m_size = 0; m_comp = 0;
    endtask

    always @(posedge clk) begin
        int lvl, mid, nw, pushn;
        bit popn;
        bit [19:0] e0, e1;
        started = 1;
        if (rst || (intf_wr && !intf_enable)) begin
            model_clear();
        end else begin
            popn  = model_valid() && snk_ready;
            lvl   = q.size();
            pushn = 0;
            e0 = '0; e1 = '0;
            if (smp_wr) begin
                if (!m_comp) begin
                    if (lvl < DEPTH) begin
                        pushn = 1;
                        e0 = ref_single(m_size, smp_data);
                    end
                end else if (lvl + 2 < DEPTH) begin
                    pushn = 2;
                    e0 = ref_half(m_size, smp_data[15:0]);
                    e1 = ref_half(m_size, smp_data[31:16]);
                end
            end
            mid = lvl + pushn;
            nw  = mid - (popn ? 2 : 0);
            if (pushn > 0) begin
                if (mid > 0) begin m_e = 0; m_u = 0; end
                if (mid >= HALF)  m_h = 0;
                if (mid >= DEPTH) m_f = 1;
            end
            if (popn) begin
                m_f = 0;
                if (nw <= HALF) m_h = 1;
                if (nw == 0) begin m_e = 1; m_u = 1; end
                void'(q.pop_front());
                void'(q.pop_front());
            end
            if (pushn >= 1) q.push_back(e0);
            if (pushn == 2) q.push_back(e1);
            m_burst = popn;
            if (ctl_wr) begin
                m_en   = ctl_tx_en;
                m_slot = ctl_slot_sel;
                m_size = int'(ctl_size);
                m_comp = ctl_compact && (ctl_size == 2'd0 || ctl_size == 2'd3);
            end
        end
    end

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        bit ev;
        bit [39:0] ep;
        if (started && !done && !rst) begin
            ev = model_valid();
            chk(snk_valid === ev, cur_req, "snk_valid (R6)", 64'(snk_valid), 64'(ev));
            if (ev) begin
                ep = {q[0], q[1]};
                chk(snk_pair === ep, cur_req, "snk_pair (R7)", 64'(snk_pair), 64'(ep));
            end
            chk({st_empty, st_half_empty, st_full, st_underrun} === {m_e, m_h, m_f, m_u},
                cur_req, "flags e/h/f/u (R5/R8)",
                64'({st_empty, st_half_empty, st_full, st_underrun}),
                64'({m_e, m_h, m_f, m_u}));
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    task automatic wr_ctl(bit en, bit [1:0] sl, bit [1:0] sz, bit cp);
        ctl_tx_en = en; ctl_slot_sel = sl; ctl_size = sz; ctl_compact = cp;
        ctl_wr = 1'b1;
        step();
        ctl_wr = 1'b0;
    endtask

    task automatic wr_smp(bit [31:0] d);
        smp_data = d;
        smp_wr = 1'b1;
        step();
        smp_wr = 1'b0;
    endtask

    task automatic clear_if();
        intf_enable = 1'b0;
        intf_wr = 1'b1;
        step();
        intf_wr = 1'b0;
        intf_enable = 1'b1;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d cycles expected=finish before limit", WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        ctl_wr = 0; ctl_tx_en = 0; ctl_slot_sel = 0; ctl_size = 0; ctl_compact = 0;
        intf_wr = 0; intf_enable = 1; smp_wr = 0; smp_data = '0; snk_ready = 1'b1;
        idle(3);
        rst = 1'b0;
        step();

        // R9: reset state
        cur_req = "R9";
        chk({st_empty, st_half_empty, st_full, st_underrun} === 4'b1100, "R9",
            "reset flags", 64'({st_empty, st_half_empty, st_full, st_underrun}), 64'h c);
        chk(snk_valid === 1'b0, "R9", "reset valid", 64'(snk_valid), 64'h0);

        // R1: each width code in single-sample mode
        cur_req = "R1";
        for (int c = 0; c < 4; c++) begin
            wr_ctl(1'b0, 2'b00, 2'(c), 1'b0);
            for (int k = 0; k < 4; k++) wr_smp(32'hFFF5_A5C3 ^ (k * 32'h0001_1111));
            wr_ctl(1'b1, 2'b01, 2'(c), 1'b0);
            idle(6);
        end
        // R8: drained to zero
        cur_req = "R8";
        chk(st_empty === 1'b1 && st_underrun === 1'b1, "R8", "empty+underrun after drain",
            64'({st_empty, st_underrun}), 64'h3);

        // R2: packed mode, 16-bit and 12-bit
        cur_req = "R2";
        wr_ctl(1'b0, 2'b00, 2'd0, 1'b1);
        wr_smp(32'h1234_ABCD);
        wr_smp(32'hFEDC_0987);
        wr_ctl(1'b1, 2'b10, 2'd0, 1'b1);
        idle(6);
        wr_ctl(1'b0, 2'b00, 2'd3, 1'b1);
        wr_smp(32'h5A5A_F00F);
        wr_smp(32'h0FFF_8001);
        wr_ctl(1'b1, 2'b10, 2'd3, 1'b1);
        idle(6);

        // R3: packed request with 18/20-bit widths falls back to single mode
        cur_req = "R3";
        for (int c = 1; c <= 2; c++) begin
            wr_ctl(1'b0, 2'b00, 2'(c), 1'b1);
            for (int k = 0; k < 4; k++) wr_smp(32'hABCD_0000 + 32'(k * 7 + c));
            wr_ctl(1'b1, 2'b11, 2'(c), 1'b1);
            idle(6);
        end

        // R4: overfill in single mode, then in packed mode
        cur_req = "R4";
        clear_if();
        wr_ctl(1'b0, 2'b00, 2'd2, 1'b0);
        for (int k = 0; k < 10; k++) wr_smp(32'h000C_0000 + 32'(k));
        chk(st_full === 1'b1, "R4", "full after overfill", 64'(st_full), 64'h1);
        wr_ctl(1'b1, 2'b01, 2'd2, 1'b0);
        idle(8);
        wr_ctl(1'b0, 2'b00, 2'd0, 1'b1);
        for (int k = 0; k < 5; k++) wr_smp(32'h1111_0000 * 32'(k + 1) + 32'(k));
        chk(st_full === 1'b0, "R4", "packed fill stops short of full", 64'(st_full), 64'h0);
        wr_ctl(1'b1, 2'b01, 2'd0, 1'b1);
        idle(8);

        // R5: flag thresholds on writes
        cur_req = "R5";
        clear_if();
        wr_ctl(1'b0, 2'b00, 2'd0, 1'b0);
        wr_smp(32'h0000_0001);
        chk(st_empty === 1'b0 && st_half_empty === 1'b1, "R5", "one entry",
            64'({st_empty, st_half_empty}), 64'h1);
        for (int k = 0; k < 3; k++) wr_smp(32'(k + 2));
        chk(st_half_empty === 1'b0, "R5", "half level reached", 64'(st_half_empty), 64'h0);

        // R6: no slot selected, then below half level
        cur_req = "R6";
        wr_ctl(1'b1, 2'b00, 2'd0, 1'b0);
        wr_smp(32'h0000_0055);
        wr_smp(32'h0000_0066);
        chk(snk_valid === 1'b0, "R6", "no slot selected", 64'(snk_valid), 64'h0);
        clear_if();
        wr_ctl(1'b1, 2'b01, 2'd0, 1'b0);
        for (int k = 0; k < 3; k++) wr_smp(32'h0000_0100 + 32'(k));
        chk(snk_valid === 1'b0, "R6", "below half level", 64'(snk_valid), 64'h0);
        wr_smp(32'h0000_0200);
        idle(4);

        // R7 and R10: backpressure with concurrent writes and control updates
        cur_req = "R7";
        clear_if();
        wr_ctl(1'b1, 2'b11, 2'd0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            smp_data  = 32'h0000_1000 + 32'(i * 37);
            smp_wr    = (i % 5) != 4;
            snk_ready = (i % 3) != 0;
            step();
        end
        smp_wr = 1'b0;
        cur_req = "R10";
        for (int i = 0; i < 20; i++) begin
            smp_data     = 32'hC0DE_0000 + 32'(i);
            smp_wr       = 1'b1;
            ctl_wr       = (i % 6) == 2;
            ctl_tx_en    = 1'b1;
            ctl_slot_sel = 2'b01;
            ctl_size     = 2'((i / 6) % 4);
            ctl_compact  = (i % 4) == 1;
            snk_ready    = (i % 4) != 3;
            step();
        end
        smp_wr = 1'b0; ctl_wr = 1'b0; snk_ready = 1'b1;
        idle(10);

        // R9: clear in the middle of a fill also resets control
        cur_req = "R9";
        wr_ctl(1'b0, 2'b00, 2'd0, 1'b0);
        for (int k = 0; k < 5; k++) wr_smp(32'(k + 9));
        wr_ctl(1'b1, 2'b01, 2'd0, 1'b0);
        clear_if();
        chk({st_empty, st_half_empty, st_full, st_underrun} === 4'b1100, "R9",
            "flags after clear", 64'({st_empty, st_half_empty, st_full, st_underrun}), 64'hc);
        for (int k = 0; k < 6; k++) wr_smp(32'(k + 20));
        chk(snk_valid === 1'b0, "R9", "transmit off after clear", 64'(snk_valid), 64'h0);
        idle(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule